// File: doc/BRIEF.md
# Host Register and Palette Interface

This block is the host-side register slave of a video encoder. An external microprocessor drives an 8-bit bus and four active-low or select strobes (chip select, register select, read and write). None of these are timed to the pixel clock. The block passes the strobes and the bus through a synchroniser and finds strobe edges in the pixel-clock domain. It keeps an address register, seven command registers and a sixteen-entry colour palette. The command registers are exported in flat form to the rest of the encoder.

Register select low reaches the address register. Register select high reaches whatever location the address register points to. A palette location is moved as a locked burst of three bytes: luma first, then red difference, then blue difference. The stored precision is reduced, and the address steps to the next entry after each completed burst. If chip select, read and write are all held low together for long enough, the block enters a strap mode. In that mode the data bus and register select are passed out as static configuration pins, and no register access is performed. A hardware reset, or a software reset bit in the first command register, restores every default. Accesses are honoured only after a short settling count that follows reset release.

Top module: `vid_host_regs`

## Requirements
- R1: With register select low, a write strobe stores the bus byte in the 8-bit address register, and a read strobe returns its full value.
- R2: With register select high and the address in 00h..06h, a write stores the byte in that command register and a read returns it. Addresses 07h..0Fh and 20h..FFh read as 00h and ignore writes.
- R3: After any reset, command register 00h holds 02h, 01h holds 01h, and 02h..06h hold 00h. `cfg_regs` carries register n on bits [8n+7:8n].
- R4: `bus_oe` is high only after a read strobe falls while chip select is low. It drops once read or chip select goes high, and it never rises while chip select is high.
- R5: At addresses 10h..1Fh, three data strobes in a row carry luma, red difference and blue difference. The entry is written only when the third byte arrives. The address then steps to the next entry, wrapping from 1Fh to 10h. A read burst returns the three bytes in the same order, taken from one snapshot of the entry.
- R6: Stored luma keeps bits [7:2], and both colour-difference bytes keep bits [7:3]. The dropped low bits read back as zero.
- R7: After any reset, every palette entry reads back as luma 00h, red difference 80h, blue difference 80h.
- R8: Writing the address register, or raising chip select, restarts the burst at luma. The bytes of a partial write are discarded, and the entry keeps its previous value.
- R9: Writing a byte with bit 7 set to command register 00h restores all command registers, the palette and the address register (00h) to their reset values.
- R10: `ready` rises on the fifth clock edge after reset is released and stays high. Strobe edges seen before that are ignored.
- R11: Chip select, read and write all low for three synchronised clocks sets `strap_mode`. While it is set, `strap_cfg` = {register select, bus}; otherwise `strap_cfg` is 0. A shorter low period does not set it, and read and write falling in the same cycle perform no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rs | input | 1 | Register select: 0 address register, 1 pointed location |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| bus_in | input | 8 | Data bus as driven by the host |
| bus_out | output | 8 | Read data returned to the host |
| bus_oe | output | 1 | Drive enable for the bus pads (0 = high impedance) |
| ready | output | 1 | High once the post-reset settling count has completed |
| strap_mode | output | 1 | Pin-strap configuration mode active |
| strap_cfg | output | 9 | {register select, bus} while in strap mode, else 0 |
| cfg_regs | output | 56 | The seven command registers, register n at bits [8n+7:8n] |

## Verification
Strap entry and register access can fall on the same clock edge. Driving chip select, read and write low at once makes both strobe edges appear in one synchronised cycle. The bench provokes this case twice: once with a pulse too short to enter strap mode, and once long enough to enter it. In both cases it then reads the address register and checks that it is unchanged, which shows that no write or read slipped through. A second overlap occurs when a palette burst is cut short by an address write or a chip-select release. That case is judged by reading the entry back after a fresh, complete burst at the same location.

// File: rtl/vid_host_pkg.sv
package vid_host_pkg;

  localparam int BYTE_W  = 8;
  localparam int Y_KEEP  = 6;
  localparam int C_KEEP  = 5;

  typedef enum logic [1:0] {
    PH_Y  = 2'd0,
    PH_CR = 2'd1,
    PH_CB = 2'd2
  } pal_phase_e;

  typedef struct packed {
    logic [Y_KEEP-1:0] y;
    logic [C_KEEP-1:0] cr;
    logic [C_KEEP-1:0] cb;
  } pal_entry_t;

  // neutral colour: luma 00h, both differences at mid-scale 80h
  localparam pal_entry_t PAL_RESET = '{y: 6'h00, cr: 5'h10, cb: 5'h10};

  function automatic logic [BYTE_W-1:0] cmd_default(input int idx);
    case (idx)
      0:       return 8'h02;
      1:       return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/vid_host_sync.sv
module vid_host_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/vid_host_rstctl.sv
module vid_host_rstctl #(
  parameter int HOLD = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = (cnt_q != LIMIT);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == LIMIT);

endmodule

// File: rtl/vid_host_palette.sv
module vid_host_palette
  import vid_host_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  pal_entry_t       wdata,
  input  logic [IDX_W-1:0] ridx,
  output pal_entry_t       rdata
);

  pal_entry_t ent [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    pal_entry_t q;
    logic       hit;

    assign hit = we && (widx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= PAL_RESET;
      else if (clr) q <= PAL_RESET;
      else if (hit) q <= wdata;
    end

    assign ent[e] = q;
  end

  assign rdata = ent[ridx];

endmodule

// File: rtl/vid_host_regs.sv
module vid_host_regs
  import vid_host_pkg::*;
#(
  parameter int          NUM_CMD     = 7,
  parameter int          PAL_DEPTH   = 16,
  parameter logic [7:0]  PAL_BASE    = 8'h10,
  parameter int          RST_HOLD    = 5,
  parameter int          STRAP_CYC   = 3,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   rs,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic [7:0]             bus_in,
  output logic [7:0]             bus_out,
  output logic                   bus_oe,
  output logic                   ready,
  output logic                   strap_mode,
  output logic [8:0]             strap_cfg,
  output logic [NUM_CMD*8-1:0]   cfg_regs
);

  localparam int         IDX_W       = $clog2(PAL_DEPTH);
  localparam int         CMD_AW      = (NUM_CMD > 1) ? $clog2(NUM_CMD) : 1;
  localparam int         RUN_W       = $clog2(STRAP_CYC + 1);
  localparam logic [7:0] NUM_CMD_B   = 8'(NUM_CMD);
  localparam logic [7:0] PAL_DEPTH_B = 8'(PAL_DEPTH);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(STRAP_CYC);

  // ---------------- synchronisers ----------------
  logic [3:0] ctl_s;
  logic [7:0] data_s;
  logic       cs_s, rs_s, rd_s, wr_s;

  vid_host_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1011)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d({cs_n, rs, rd_n, wr_n}), .q(ctl_s)
  );

  vid_host_sync #(.W(8), .STAGES(SYNC_STAGES), .RST_VAL(8'h00)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(data_s)
  );

  assign {cs_s, rs_s, rd_s, wr_s} = ctl_s;

  vid_host_rstctl #(.HOLD(RST_HOLD)) u_rstctl (
    .clk(clk), .rst_n(rst_n), .ready(ready)
  );

  // ---------------- state ----------------
  logic             cs_p, rd_p, wr_p;
  logic [RUN_W-1:0] run_q, run_d;
  logic [7:0]       addr_q, addr_d;
  pal_phase_e       phase_q, phase_d;
  logic [5:0]       sy_q, sy_d;
  logic [4:0]       scr_q, scr_d;
  pal_entry_t       snap_q, snap_d;
  logic [7:0]       rdata_q, rdata_d;
  logic             oe_q, oe_d;
  logic [7:0]       cmd_q [NUM_CMD];
  logic [7:0]       cmd_d [NUM_CMD];

  // ---------------- decode ----------------
  logic             rd_fall, wr_fall, cs_rise, all_low, live;
  logic             do_wr, do_rd, soft_rst;
  logic             cmd_hit, pal_hit;
  logic [7:0]       pal_off, addr_inc;
  logic [IDX_W-1:0] pal_idx, idx_inc;
  logic [CMD_AW-1:0] cmd_idx;
  logic             pal_we, pal_clr;
  pal_entry_t       pal_wdata, pal_rdata;

  always_comb begin
    rd_fall    = rd_p & ~rd_s;
    wr_fall    = wr_p & ~wr_s;
    cs_rise    = ~cs_p & cs_s;
    all_low    = ~cs_s & ~rd_s & ~wr_s;
    strap_mode = ready & (run_q == RUN_LIM);
    live       = ready & ~strap_mode & ~cs_s;
    do_wr      = live & wr_fall & ~rd_fall;
    do_rd      = live & rd_fall & ~wr_fall;

    cmd_hit    = (addr_q < NUM_CMD_B);
    cmd_idx    = addr_q[CMD_AW-1:0];
    pal_off    = addr_q - PAL_BASE;
    pal_hit    = (addr_q >= PAL_BASE) && (pal_off < PAL_DEPTH_B);
    pal_idx    = pal_off[IDX_W-1:0];
    idx_inc    = IDX_W'(pal_idx + 1'b1);
    addr_inc   = PAL_BASE + 8'(idx_inc);
  end

  always_comb begin
    if (all_low) run_d = (run_q == RUN_LIM) ? run_q : run_q + 1'b1;
    else         run_d = '0;
  end

  vid_host_palette #(.DEPTH(PAL_DEPTH), .IDX_W(IDX_W)) u_pal (
    .clk(clk), .rst_n(rst_n), .clr(pal_clr), .we(pal_we), .widx(pal_idx),
    .wdata(pal_wdata), .ridx(pal_idx), .rdata(pal_rdata)
  );

  // ---------------- next state ----------------
  always_comb begin
    addr_d    = addr_q;
    phase_d   = phase_q;
    sy_d      = sy_q;
    scr_d     = scr_q;
    snap_d    = snap_q;
    rdata_d   = rdata_q;
    oe_d      = oe_q;
    cmd_d     = cmd_q;
    pal_we    = 1'b0;
    pal_clr   = 1'b0;
    pal_wdata = '{y: sy_q, cr: scr_q, cb: data_s[7:3]};
    soft_rst  = 1'b0;

    if (cs_rise) phase_d = PH_Y;
    if (cs_s || rd_s || strap_mode) oe_d = 1'b0;

    if (do_wr) begin
      if (!rs_s) begin
        addr_d  = data_s;
        phase_d = PH_Y;
      end else if (cmd_hit) begin
        if (cmd_idx == '0 && data_s[7]) soft_rst = 1'b1;
        else                            cmd_d[cmd_idx] = data_s;
      end else if (pal_hit) begin
        case (phase_q)
          PH_Y: begin
            sy_d    = data_s[7:2];
            phase_d = PH_CR;
          end
          PH_CR: begin
            scr_d   = data_s[7:3];
            phase_d = PH_CB;
          end
          PH_CB: begin
            pal_we  = 1'b1;
            phase_d = PH_Y;
            addr_d  = addr_inc;
          end
          default: phase_d = PH_Y;
        endcase
      end
    end

    if (do_rd) begin
      oe_d = 1'b1;
      if (!rs_s) begin
        rdata_d = addr_q;
      end else if (cmd_hit) begin
        rdata_d = cmd_q[cmd_idx];
      end else if (pal_hit) begin
        case (phase_q)
          PH_Y: begin
            snap_d  = pal_rdata;
            rdata_d = {pal_rdata.y, 2'b00};
            phase_d = PH_CR;
          end
          PH_CR: begin
            rdata_d = {snap_q.cr, 3'b000};
            phase_d = PH_CB;
          end
          PH_CB: begin
            rdata_d = {snap_q.cb, 3'b000};
            phase_d = PH_Y;
            addr_d  = addr_inc;
          end
          default: phase_d = PH_Y;
        endcase
      end else begin
        rdata_d = 8'h00;
      end
    end

    if (soft_rst) begin
      addr_d  = 8'h00;
      phase_d = PH_Y;
      sy_d    = '0;
      scr_d   = '0;
      snap_d  = PAL_RESET;
      rdata_d = 8'h00;
      pal_clr = 1'b1;
      for (int i = 0; i < NUM_CMD; i++) cmd_d[i] = cmd_default(i);
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p    <= 1'b1;
      rd_p    <= 1'b1;
      wr_p    <= 1'b1;
      run_q   <= '0;
      addr_q  <= 8'h00;
      phase_q <= PH_Y;
      sy_q    <= '0;
      scr_q   <= '0;
      snap_q  <= PAL_RESET;
      rdata_q <= 8'h00;
      oe_q    <= 1'b0;
      for (int i = 0; i < NUM_CMD; i++) cmd_q[i] <= cmd_default(i);
    end else begin
      cs_p    <= cs_s;
      rd_p    <= rd_s;
      wr_p    <= wr_s;
      run_q   <= run_d;
      addr_q  <= addr_d;
      phase_q <= phase_d;
      sy_q    <= sy_d;
      scr_q   <= scr_d;
      snap_q  <= snap_d;
      rdata_q <= rdata_d;
      oe_q    <= oe_d;
      cmd_q   <= cmd_d;
    end
  end

  // ---------------- outputs ----------------
  for (genvar i = 0; i < NUM_CMD; i++) begin : g_cfg
    assign cfg_regs[i*8 +: 8] = cmd_q[i];
  end

  assign strap_cfg = strap_mode ? {rs_s, data_s} : 9'h000;
  assign bus_out   = rdata_q;
  assign bus_oe    = oe_q;

endmodule

// File: rtl/vid_host_regs_chk.sv
module vid_host_regs_chk
  import vid_host_pkg::*;
#(
  parameter int NUM_CMD = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ready,
  input logic                 bus_oe,
  input logic                 strap_mode,
  input logic [8:0]           strap_cfg,
  input logic [NUM_CMD*8-1:0] cfg_regs
);

  // R4 / R11: the bus is never driven while the strap pins are being read
  a_r4_no_drive_in_strap: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !strap_mode);

  // R10: nothing is driven and no strap mode before settling completes
  a_r10_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!bus_oe && !strap_mode));

  // R10: ready stays high once raised
  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R11: configuration pins read as zero outside strap mode
  a_r11_cfg_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_mode |-> (strap_cfg == 9'h000));

  // R3: command registers hold their defaults when ready first rises
  for (genvar i = 0; i < NUM_CMD; i++) begin : g_def
    a_r3_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (cfg_regs[i*8 +: 8] == cmd_default(i)));
  end

endmodule

bind vid_host_regs vid_host_regs_chk #(.NUM_CMD(NUM_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .bus_oe(bus_oe),
  .strap_mode(strap_mode), .strap_cfg(strap_cfg), .cfg_regs(cfg_regs)
);

// File: tb/vid_host_regs_test.sv
module vid_host_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCMD       = 7;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cs_n, rs, rd_n, wr_n;
  logic [7:0]      bus_in;
  logic [7:0]      bus_out;
  logic            bus_oe;
  logic            ready;
  logic            strap_mode;
  logic [8:0]      strap_cfg;
  logic [NCMD*8-1:0] cfg_regs;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_host_regs uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ready(ready),
    .strap_mode(strap_mode), .strap_cfg(strap_cfg), .cfg_regs(cfg_regs)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; tick(1);
  endtask

  task automatic cs_hi();
    cs_n = 1'b1; tick(4);
  endtask

  task automatic bwr(input logic sel, input logic [7:0] d);
    rs = sel; bus_in = d; tick(1);
    wr_n = 1'b0; tick(4);
    wr_n = 1'b1; tick(4);
  endtask

  task automatic brd(input logic sel, output logic [7:0] d, output logic oe);
    rs = sel; tick(1);
    rd_n = 1'b0; tick(4);
    d = bus_out; oe = bus_oe;
    rd_n = 1'b1; tick(4);
  endtask

  function automatic logic [7:0] cmd_exp_default(input int i);
    return (i == 0) ? 8'h02 : (i == 1) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] cmd_pat(input int i);
    return 8'((i * 45 + 19) & 8'h7F);
  endfunction

  function automatic logic [7:0] py(input int i);  return 8'(i * 17 + 3);  endfunction
  function automatic logic [7:0] pcr(input int i); return 8'(i * 29 + 7);  endfunction
  function automatic logic [7:0] pcb(input int i); return 8'(i * 53 + 11); endfunction

  task automatic chk_defaults(input string tag);
    for (int i = 0; i < NCMD; i++)
      chk(tag, {8'h00, cfg_regs[i*8 +: 8]}, {8'h00, cmd_exp_default(i)});
  endtask

  task automatic chk_entry(input string tag, input logic [7:0] ey, input logic [7:0] ecr,
                           input logic [7:0] ecb);
    logic [7:0] d; logic oe;
    brd(1'b1, d, oe); chk({tag, " luma"}, {8'h00, d}, {8'h00, ey});
    brd(1'b1, d, oe); chk({tag, " cr"},   {8'h00, d}, {8'h00, ecr});
    brd(1'b1, d, oe); chk({tag, " cb"},   {8'h00, d}, {8'h00, ecb});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       oe;
    logic [7:0] a_before;
    bit         seen;

    rst_n = 1'b0; cs_n = 1'b1; rs = 1'b0; rd_n = 1'b1; wr_n = 1'b1; bus_in = 8'h00;
    tick(6);
    chk("R10 ready low in reset", {15'h0, ready}, 16'h0);
    chk("R4 no drive in reset", {15'h0, bus_oe}, 16'h0);
    chk("R11 strap idle in reset", {7'h0, strap_cfg}, 16'h0);

    // R10: a write strobe falling during the settling window is ignored
    cs_n = 1'b0; rs = 1'b0; bus_in = 8'h55; wr_n = 1'b0;
    tick(1);
    rst_n = 1'b1;
    tick(4);
    chk("R10 ready low after 4 edges", {15'h0, ready}, 16'h0);
    tick(1);
    chk("R10 ready high after 5 edges", {15'h0, ready}, 16'h1);
    wr_n = 1'b1; tick(4);
    cs_hi();
    chk_defaults("R3 command defaults");
    cs_lo(); brd(1'b0, d, oe); cs_hi();
    chk("R10 early write ignored", {8'h00, d}, 16'h0000);
    chk("R4 oe during read", {15'h0, oe}, 16'h1);
    chk("R4 oe released", {15'h0, bus_oe}, 16'h0);

    // R4: a read strobe with chip select high never drives the bus
    rd_n = 1'b0; tick(4);
    chk("R4 no drive with cs high", {15'h0, bus_oe}, 16'h0);
    rd_n = 1'b1; tick(4);

    // R7: palette defaults at first and last entry
    cs_lo();
    bwr(1'b0, 8'h10); chk_entry("R7 entry0", 8'h00, 8'h80, 8'h80);
    bwr(1'b0, 8'h1F); chk_entry("R7 entry15", 8'h00, 8'h80, 8'h80);
    cs_hi();

    // R1: address register sweep over all byte values
    for (int a = 0; a < 256; a++) begin
      cs_lo();
      bwr(1'b0, 8'(a));
      brd(1'b0, d, oe);
      cs_hi();
      chk("R1 address readback", {8'h00, d}, 16'(a));
    end

    // R2: command registers
    cs_lo();
    for (int i = 0; i < NCMD; i++) begin
      bwr(1'b0, 8'(i)); bwr(1'b1, cmd_pat(i));
    end
    for (int i = 0; i < NCMD; i++) begin
      bwr(1'b0, 8'(i)); brd(1'b1, d, oe);
      chk("R2 command readback", {8'h00, d}, {8'h00, cmd_pat(i)});
      chk("R3 cfg_regs mapping", {8'h00, cfg_regs[i*8 +: 8]}, {8'h00, cmd_pat(i)});
    end
    cs_hi();

    // R2: unmapped addresses read zero and writes leave command registers alone
    for (int a = NCMD; a < 256; a++) begin
      if (a >= 16 && a < 32) continue;
      cs_lo();
      bwr(1'b0, 8'(a)); bwr(1'b1, 8'hC3); brd(1'b1, d, oe);
      cs_hi();
      chk("R2 unmapped reads zero", {8'h00, d}, 16'h0000);
    end
    for (int i = 0; i < NCMD; i++)
      chk("R2 unmapped write no effect", {8'h00, cfg_regs[i*8 +: 8]}, {8'h00, cmd_pat(i)});

    // R5 / R6: full palette burst with auto-increment and wrap
    cs_lo();
    bwr(1'b0, 8'h10);
    for (int i = 0; i < 16; i++) begin
      bwr(1'b1, py(i)); bwr(1'b1, pcr(i)); bwr(1'b1, pcb(i));
    end
    brd(1'b0, d, oe);
    chk("R5 address wraps to 10h", {8'h00, d}, 16'h0010);
    for (int i = 0; i < 16; i++)
      chk_entry("R6 truncated entry", py(i) & 8'hFC, pcr(i) & 8'hF8, pcb(i) & 8'hF8);
    brd(1'b0, d, oe);
    chk("R5 read burst wraps", {8'h00, d}, 16'h0010);
    cs_hi();

    // R8: partial write cut by chip select release
    cs_lo(); bwr(1'b0, 8'h13); bwr(1'b1, 8'hAA); bwr(1'b1, 8'hBB); cs_hi();
    cs_lo(); bwr(1'b0, 8'h13);
    chk_entry("R8 cs abort keeps entry", py(3) & 8'hFC, pcr(3) & 8'hF8, pcb(3) & 8'hF8);
    cs_hi();

    // R8: partial write cut by address write
    cs_lo();
    bwr(1'b0, 8'h14); bwr(1'b1, 8'h11);
    bwr(1'b0, 8'h14);
    bwr(1'b1, 8'h44); bwr(1'b1, 8'h55); bwr(1'b1, 8'h66);
    brd(1'b0, d, oe);
    chk("R5 step after burst", {8'h00, d}, 16'h0015);
    bwr(1'b0, 8'h14);
    chk_entry("R8 restart at luma", 8'h44, 8'h50, 8'h60);
    cs_hi();

    // R11: short all-low pulse does not enter strap mode and performs no access
    cs_lo(); bwr(1'b0, 8'h3A); cs_hi();
    rs = 1'b1; bus_in = 8'hA5;
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    tick(2);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (strap_mode) seen = 1'b1;
      tick(1);
    end
    chk("R11 short pulse no strap", {15'h0, seen}, 16'h0);
    cs_lo(); brd(1'b0, a_before, oe); cs_hi();
    chk("R11 short pulse no access", {8'h00, a_before}, 16'h003A);

    // R11: long all-low period enters strap mode
    rs = 1'b1; bus_in = 8'hA5;
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    tick(8);
    chk("R11 strap entered", {15'h0, strap_mode}, 16'h1);
    chk("R11 strap pins", {7'h0, strap_cfg}, 16'h01A5);
    chk("R4 no drive in strap", {15'h0, bus_oe}, 16'h0);
    rs = 1'b0; bus_in = 8'h3C; tick(4);
    chk("R11 strap pins follow", {7'h0, strap_cfg}, 16'h003C);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; tick(6);
    chk("R11 strap left", {15'h0, strap_mode}, 16'h0);
    chk("R11 strap cfg cleared", {7'h0, strap_cfg}, 16'h0);
    cs_lo(); brd(1'b0, d, oe); cs_hi();
    chk("R11 strap no access", {8'h00, d}, 16'h003A);

    // R9: software reset
    cs_lo();
    bwr(1'b0, 8'h00); bwr(1'b1, 8'h80);
    chk_defaults("R9 soft reset commands");
    brd(1'b0, d, oe);
    chk("R9 soft reset address", {8'h00, d}, 16'h0000);
    bwr(1'b0, 8'h15);
    chk_entry("R9 soft reset palette", 8'h00, 8'h80, 8'h80);
    cs_hi();

    // R3 / R7: hardware reset in mid-run
    cs_lo(); bwr(1'b0, 8'h02); bwr(1'b1, 8'h5E); bwr(1'b0, 8'h12);
    bwr(1'b1, 8'hFF); bwr(1'b1, 8'hFF); bwr(1'b1, 8'hFF); cs_hi();
    rst_n = 1'b0; tick(6); rst_n = 1'b1; tick(8);
    chk("R10 ready after hard reset", {15'h0, ready}, 16'h1);
    chk_defaults("R3 hard reset commands");
    cs_lo(); bwr(1'b0, 8'h12);
    chk_entry("R7 hard reset palette", 8'h00, 8'h80, 8'h80);
    cs_hi();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule